// File: doc/BRIEF.md
# VME Short-I/O Slave Decoder for an 8-bit Parallel I/O Bus

This block is the bus-facing front end of a bridge between a VMEbus A16 slave port and an 8-bit parallel I/O bus. It watches the address strobe, the data strobes, the address modifier and the read/write line. It claims cycles that fall inside its own 1 KB window and turns each one into a remote bank access or a control action.

A bank access raises a request toward a downstream strobe sequencer. The request carries a 6-bit bank number and the transfer direction. The sequencer's done pulse is then turned into the bus acknowledge.

A control write changes the active-low remote reset line and is acknowledged without any remote strobe. The remote reset is driven active by system reset and stays active until software releases it.

Bus control strobes pass through two-flop synchronisers into the block clock before they are decoded. Address and modifier lines are sampled directly, because the bus holds them stable while the address strobe is active.

Top module: `shortio_slave_decode`

## Requirements
- R1: A cycle is claimed only when address bits A15..A10 equal `base_strap` and A9..A8 are both 0. Any other address gets no acknowledge and no bank request.
- R2: With `sup_only` = 1, only modifier 0x2D is claimed. Modifier 0x29 is ignored.
- R3: With `sup_only` = 0, both 0x2D and 0x29 are claimed. Every other modifier is ignored.
- R4: A cycle is claimed only while DS0* is low. A single-byte cycle with only DS1* low gets no response. A word cycle with both strobes low is claimed.
- R5: A claimed cycle with A7 = 0 is a bank access. `bank_req` rises with `bank_addr` = A6..A1, so byte offset 2n+1 reaches bank n. `bank_write` is 1 for a write (WRITE* low). `bank_req` stays high until `seq_done` is seen.
- R6: DTACK* goes low only after a bank access completes or a control access is decoded. It never goes low together with `bank_req`. It stays low until DS0* and DS1* are both high, and it returns high within 4 clocks after that.
- R7: A claimed write with A7 = 1 is a control write. A6 = 1 (offset 0xC1) drives `remote_rst_n` high, and A6 = 0 (offset 0x81) drives it low. The write is acknowledged without raising `bank_req`.
- R8: `remote_rst_n` is 0 during and after `rst_n` low, and it stays 0 until a release write. A read at a control offset is acknowledged and leaves `remote_rst_n` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (16 MHz) |
| rst_n | input | 1 | System reset, active low, asynchronous |
| addr | input | 15 | Bus address A15..A1 |
| am | input | 6 | Address modifier code |
| as_n | input | 1 | Address strobe, active low |
| ds0_n | input | 1 | Odd-byte data strobe, active low |
| ds1_n | input | 1 | Even-byte data strobe, active low |
| write_n | input | 1 | Low for a write cycle |
| base_strap | input | 6 | Window select, compared with A15..A10 |
| sup_only | input | 1 | 1: accept supervisory modifier only |
| seq_done | input | 1 | One-clock done pulse from the strobe sequencer |
| bank_req | output | 1 | Remote bank access request |
| bank_addr | output | 6 | Remote bank number |
| bank_write | output | 1 | 1 when the bank access is a write |
| dtack_n | output | 1 | Data transfer acknowledge, active low |
| remote_rst_n | output | 1 | Remote reset, active low |

## Verification
The hardest case to reach from the ports is a remote reset that goes back to active after software has released it. The stimulus first performs a release write and confirms the line is high. It then pulses system reset in the middle of the run, which drives the line low again. A control read placed in between shows that only writes change the line. A small sequencer model inside the bench answers each bank request after a fixed delay, so the acknowledge path through the done pulse is exercised for both reads and writes.

// File: rtl/shortio_slave_decode.sv
module shortio_slave_decode #(
  parameter logic [5:0] AM_SUPER = 6'h2D,
  parameter logic [5:0] AM_USER  = 6'h29
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:1] addr,
  input  logic [5:0]  am,
  input  logic        as_n,
  input  logic        ds0_n,
  input  logic        ds1_n,
  input  logic        write_n,
  input  logic [5:0]  base_strap,
  input  logic        sup_only,
  input  logic        seq_done,
  output logic        bank_req,
  output logic [5:0]  bank_addr,
  output logic        bank_write,
  output logic        dtack_n,
  output logic        remote_rst_n
);

  typedef enum logic [1:0] {S_IDLE, S_BANK, S_ACK} state_t;

  state_t     state;
  logic [1:0] as_q, ds0_q, ds1_q, wr_q;
  logic       rrst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      as_q  <= 2'b11;
      ds0_q <= 2'b11;
      ds1_q <= 2'b11;
      wr_q  <= 2'b11;
    end else begin
      as_q  <= {as_q[0], as_n};
      ds0_q <= {ds0_q[0], ds0_n};
      ds1_q <= {ds1_q[0], ds1_n};
      wr_q  <= {wr_q[0], write_n};
    end
  end

  wire am_ok = (am == AM_SUPER) || (!sup_only && am == AM_USER);
  wire in_win = (addr[15:10] == base_strap) && (addr[9:8] == 2'b00);
  wire sel = !as_q[1] && !ds0_q[1] && in_win && am_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      rrst_q <= 1'b0;
    end else begin
      case (state)
        S_IDLE:
          if (sel) begin
            if (addr[7]) begin
              if (!wr_q[1]) rrst_q <= addr[6];
              state <= S_ACK;
            end else begin
              state <= S_BANK;
            end
          end
        S_BANK:
          if (seq_done) state <= S_ACK;
        S_ACK:
          if (ds0_q[1] && ds1_q[1]) state <= S_IDLE;
        default:
          state <= S_IDLE;
      endcase
    end
  end

  assign bank_req     = (state == S_BANK);
  assign bank_addr    = addr[6:1];
  assign bank_write   = !wr_q[1];
  assign dtack_n      = (state != S_ACK);
  assign remote_rst_n = rrst_q;

endmodule

// File: rtl/shortio_slave_decode_chk.sv
module shortio_slave_decode_chk (
  input logic clk,
  input logic rst_n,
  input logic bank_req,
  input logic seq_done,
  input logic dtack_n,
  input logic remote_rst_n
);

  assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_req && !seq_done) |=> bank_req);

  assert_ack_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !dtack_n |-> !bank_req);

  assert_release_acked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(remote_rst_n) |-> $fell(dtack_n));

  assert_rst_no_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(remote_rst_n) |-> !bank_req);

  assert_assert_acked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(remote_rst_n) |-> $fell(dtack_n));

endmodule

bind shortio_slave_decode shortio_slave_decode_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bank_req(bank_req), .seq_done(seq_done),
  .dtack_n(dtack_n), .remote_rst_n(remote_rst_n)
);

// File: tb/sim_shortio_slave_decode.sv
module sim_shortio_slave_decode;
  localparam int CLK_PERIOD = 62;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:1] addr = '0;
  logic [5:0]  am = 6'h2D;
  logic        as_n = 1'b1, ds0_n = 1'b1, ds1_n = 1'b1, write_n = 1'b1;
  logic [5:0]  base_strap = 6'h04;
  logic        sup_only = 1'b1;
  logic        seq_done = 1'b0;
  logic        bank_req, bank_write, dtack_n, remote_rst_n;
  logic [5:0]  bank_addr;

  int checks = 0, fails = 0;
  int seq_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shortio_slave_decode u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .am(am), .as_n(as_n),
    .ds0_n(ds0_n), .ds1_n(ds1_n), .write_n(write_n),
    .base_strap(base_strap), .sup_only(sup_only), .seq_done(seq_done),
    .bank_req(bank_req), .bank_addr(bank_addr), .bank_write(bank_write),
    .dtack_n(dtack_n), .remote_rst_n(remote_rst_n)
  );

  always @(posedge clk) begin
    if (bank_req) begin
      seq_cnt  <= seq_cnt + 1;
      seq_done <= (seq_cnt == 3);
    end else begin
      seq_cnt  <= 0;
      seq_done <= 1'b0;
    end
  end

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  logic got_ack, got_bank, got_wr, rel_ok;
  logic [5:0] got_baddr;

  task automatic bus_cycle(input logic [15:0] off, input logic [5:0] code,
                           input logic wr, input logic d0, input logic d1);
    got_ack = 0; got_bank = 0; got_wr = 0; got_baddr = '0; rel_ok = 1;
    @(negedge clk);
    addr = {base_strap, 10'h000}[15:1] | off[15:1];
    am = code; write_n = !wr; as_n = 0;
    @(negedge clk);
    ds0_n = d0; ds1_n = d1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (bank_req) begin got_bank = 1; got_baddr = bank_addr; got_wr = bank_write; end
      if (!dtack_n) begin got_ack = 1; break; end
    end
    ds0_n = 1; ds1_n = 1; as_n = 1;
    repeat (4) @(negedge clk);
    rel_ok = dtack_n;
    repeat (2) @(negedge clk);
  endtask

  task automatic raw_cycle(input logic [15:0] full, input logic wr);
    got_ack = 0; got_bank = 0;
    @(negedge clk);
    addr = full[15:1]; am = 6'h2D; write_n = !wr; as_n = 0;
    @(negedge clk);
    ds0_n = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (bank_req) got_bank = 1;
      if (!dtack_n) got_ack = 1;
    end
    ds0_n = 1; as_n = 1;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R8 reset remote_rst_n", remote_rst_n, 0);
    check("R6 reset dtack_n", dtack_n, 1);
    check("R5 reset bank_req", bank_req, 0);
  endtask

  task automatic t_bank_read;
    bus_cycle(16'h0019, 6'h2D, 0, 0, 1);
    check("R1 match ack", got_ack, 1);
    check("R5 bank req", got_bank, 1);
    check("R5 bank 12 addr", got_baddr, 12);
    check("R5 read dir", got_wr, 0);
    check("R6 dtack release", rel_ok, 1);
  endtask

  task automatic t_bank_write;
    bus_cycle(16'h007F, 6'h2D, 1, 0, 1);
    check("R5 bank 63 addr", got_baddr, 63);
    check("R5 write dir", got_wr, 1);
    check("R6 write ack", got_ack, 1);
    check("R6 dtack release", rel_ok, 1);
  endtask

  task automatic t_base_miss;
    raw_cycle(16'h1419, 0);
    check("R1 other window ack", got_ack, 0);
    check("R1 other window req", got_bank, 0);
    raw_cycle(16'h1119, 0);
    check("R1 A8 set ack", got_ack, 0);
    raw_cycle(16'h1003, 0);
    check("R1 own window ack", got_ack, 1);
  endtask

  task automatic t_modifiers;
    sup_only = 1;
    bus_cycle(16'h0003, 6'h29, 0, 0, 1);
    check("R2 user am rejected", got_ack, 0);
    bus_cycle(16'h0003, 6'h2D, 0, 0, 1);
    check("R2 super am accepted", got_ack, 1);
    sup_only = 0;
    bus_cycle(16'h0003, 6'h29, 0, 0, 1);
    check("R3 user am accepted", got_ack, 1);
    bus_cycle(16'h0003, 6'h2D, 0, 0, 1);
    check("R3 super am accepted", got_ack, 1);
    bus_cycle(16'h0003, 6'h39, 0, 0, 1);
    check("R3 other am rejected", got_ack, 0);
    check("R3 other am no req", got_bank, 0);
    sup_only = 1;
  endtask

  task automatic t_strobes;
    bus_cycle(16'h0005, 6'h2D, 0, 1, 0);
    check("R4 even byte ack", got_ack, 0);
    check("R4 even byte req", got_bank, 0);
    bus_cycle(16'h0005, 6'h2D, 0, 0, 0);
    check("R4 word ack", got_ack, 1);
    check("R4 word bank 2", got_baddr, 2);
  endtask

  task automatic t_control;
    bus_cycle(16'h00C1, 6'h2D, 0, 0, 1);
    check("R8 ctrl read ack", got_ack, 1);
    check("R8 ctrl read keeps reset", remote_rst_n, 0);
    bus_cycle(16'h00C1, 6'h2D, 1, 0, 1);
    check("R7 release ack", got_ack, 1);
    check("R7 release no strobe", got_bank, 0);
    check("R7 release level", remote_rst_n, 1);
    bus_cycle(16'h0081, 6'h2D, 1, 0, 1);
    check("R7 assert no strobe", got_bank, 0);
    check("R7 assert level", remote_rst_n, 0);
    bus_cycle(16'h00C1, 6'h2D, 1, 0, 1);
    check("R7 release again", remote_rst_n, 1);
    bus_cycle(16'h00C1, 6'h2D, 0, 0, 1);
    check("R8 ctrl read keeps release", remote_rst_n, 1);
  endtask

  task automatic t_sysreset;
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    check("R8 sysreset asserts", remote_rst_n, 0);
    rst_n = 1;
    repeat (10) @(negedge clk);
    check("R8 stays asserted", remote_rst_n, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset();
    t_bank_read();
    t_bank_write();
    t_base_miss();
    t_modifiers();
    t_strobes();
    t_control();
    t_sysreset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule